// File: doc/BRIEF.md
# Periodic Event Comparator

This block watches a 64-bit running count that arrives from outside and raises an event when the count reaches a target value held in software-visible registers. Software writes the 64-bit target as two 32-bit halves and writes a 32-bit step value into a separate register. When a match occurs, a sticky status bit is set. That bit drives the interrupt line through an enable mask, and software clears it by writing a one to it.

With the step mode switched on, the target advances by the step after every match, wrapping modulo 2^64. This produces a steady train of events without software rewriting the target each time. Every write to a target half, the step register or the control register sets a write-done flag. Software can poll that flag and clear it.

Top module: `event_comparator`

## Requirements
- R1: After reset, every register reads zero, irq is low, and reads of any address return zero until something is written.
- R2: Word addresses: 0 target low half, 1 target high half, 2 step, 3 control (bit 0 = compare on, bit 1 = step mode), 4 event status (bit 0), 5 interrupt mask (bit 0), 6 write-done flags. Target, step, control and mask read back what was written.
- R3: When control bit 0 is set and countIn equals the 64-bit target, event status bit 0 reads 1 after the next rising edge. The count must also differ from its value in the previous cycle, or this must be the first cycle after reset.
- R4: With control bit 0 clear, no match is taken, whatever countIn and the target hold.
- R5: A count that stays unchanged produces at most one match, even if it still equals the target.
- R6: With control bits 1 and 0 both set, a match replaces the target with target + step (step zero-extended, sum modulo 2^64). The new value is readable one cycle later.
- R7: With control bit 1 clear, a match leaves the target unchanged.
- R8: Writing 1 to status bit 0 clears it, and writing 0 leaves it unchanged. If a match and a clear fall in the same cycle, the bit ends up set.
- R9: irq is high exactly when status bit 0 and mask bit 0 are both 1.
- R10: The write-done flags are bit 0 (target low), bit 1 (target high), bit 2 (step) and bit 16 (control). A write to the named register sets its flag. Writing 1 to a flag bit at address 6 clears that flag.
- R11: A software write to a target half in the same cycle as a stepping match wins. The written half takes the new data, the other half is unchanged, and no step is added.
- R12: Writes to addresses 7 and above change nothing, and reads of those addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| countIn | input | 64 | Free-running count to compare against |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register write word address |
| wrData | input | 32 | Register write data |
| rdAddr | input | 4 | Register read word address |
| rdData | output | 32 | Register read data (combinational) |
| irq | output | 1 | Event interrupt, status AND mask |

## Verification
On every cycle, the assertions check the following. A match always latches status. No match occurs while comparing is off or while the count is held. A stepping match moves the target by exactly the step, and a non-stepping match leaves it alone. A write sets its write-done flag, and irq never rises without the mask. Only the bench's scenarios show the rest: the carry from the low half into the high half, the wrap past 2^64, set-over-clear ordering, the precedence of a software write over a step, and the register map seen through reads.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

  // Word addresses of the register file
  localparam int OFS_CMP_LO = 0;
  localparam int OFS_CMP_HI = 1;
  localparam int OFS_STEP   = 2;
  localparam int OFS_CTRL   = 3;
  localparam int OFS_STAT   = 4;
  localparam int OFS_MASK   = 5;
  localparam int OFS_WDONE  = 6;

  // Bit positions inside the write-done register
  localparam int WD_BIT_LO   = 0;
  localparam int WD_BIT_HI   = 1;
  localparam int WD_BIT_STEP = 2;
  localparam int WD_BIT_CTRL = 16;

  // Strobes from the control side to the datapath
  typedef struct packed {
    logic ldLo;
    logic ldHi;
    logic ldStep;
    logic cmpOn;
    logic stepMode;
  } cmpStrobes_t;

endpackage

// File: rtl/cmp_datapath.sv
module cmp_datapath
  import cmp_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmpStrobes_t       st,
  input  logic [DATA_W-1:0] wrData,
  input  logic [CNT_W-1:0]  countIn,
  output logic              match,
  output logic [DATA_W-1:0] cmpLoRd,
  output logic [DATA_W-1:0] cmpHiRd,
  output logic [DATA_W-1:0] stepRd
);

  localparam int HI_W = CNT_W - DATA_W;

  logic [CNT_W-1:0]  cmpVal;
  logic [CNT_W-1:0]  cmpNext;
  logic [DATA_W-1:0] stepReg;
  logic [CNT_W-1:0]  prevCount;
  logic              countValid;
  logic              countChanged;
  logic              swLoad;

  assign countChanged = !countValid || (countIn != prevCount);
  assign match        = st.cmpOn && countChanged && (countIn == cmpVal);
  assign swLoad       = st.ldLo || st.ldHi;

  always_comb begin
    cmpNext = cmpVal;
    if (st.ldLo) cmpNext[DATA_W-1:0] = wrData;
    if (st.ldHi) cmpNext[CNT_W-1:DATA_W] = HI_W'(wrData);
    if (!swLoad && match && st.stepMode)
      cmpNext = cmpVal + CNT_W'(stepReg);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpVal     <= '0;
      stepReg    <= '0;
      prevCount  <= '0;
      countValid <= 1'b0;
    end else begin
      cmpVal     <= cmpNext;
      prevCount  <= countIn;
      countValid <= 1'b1;
      if (st.ldStep) stepReg <= wrData;
    end
  end

  assign cmpLoRd = cmpVal[DATA_W-1:0];
  assign cmpHiRd = DATA_W'(cmpVal[CNT_W-1:DATA_W]);
  assign stepRd  = stepReg;

  // R4: no match while comparing is off
  a_r4_off_no_match: assert property (@(posedge clk) disable iff (!rstN)
    !st.cmpOn |-> !match);

  // R5: a held count never matches again
  a_r5_held_no_match: assert property (@(posedge clk) disable iff (!rstN)
    (countValid && $stable(countIn)) |-> !match);

  // R6: a stepping match moves the target by the step
  a_r6_step_add: assert property (@(posedge clk) disable iff (!rstN)
    (match && st.stepMode && !swLoad) |=>
      (cmpVal == $past(cmpVal) + CNT_W'($past(stepReg))));

  // R7: a plain match keeps the target
  a_r7_plain_hold: assert property (@(posedge clk) disable iff (!rstN)
    (match && !st.stepMode && !swLoad) |=> $stable(cmpVal));

endmodule

// File: rtl/cmp_ctrl.sv
module cmp_ctrl
  import cmp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              match,
  input  logic [DATA_W-1:0] cmpLoRd,
  input  logic [DATA_W-1:0] cmpHiRd,
  input  logic [DATA_W-1:0] stepRd,
  output cmpStrobes_t       st,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);

  localparam int WD_N = 4;

  logic [1:0]      ctrlReg;
  logic            maskReg;
  logic            statReg;
  logic [WD_N-1:0] wdReg;
  logic [WD_N-1:0] wdSet;
  logic [WD_N-1:0] wdClr;

  logic hitLo, hitHi, hitStep, hitCtrl, hitStat, hitMask, hitWd;
  logic unusedData;

  assign hitLo   = wrEn && (wrAddr == ADDR_W'(OFS_CMP_LO));
  assign hitHi   = wrEn && (wrAddr == ADDR_W'(OFS_CMP_HI));
  assign hitStep = wrEn && (wrAddr == ADDR_W'(OFS_STEP));
  assign hitCtrl = wrEn && (wrAddr == ADDR_W'(OFS_CTRL));
  assign hitStat = wrEn && (wrAddr == ADDR_W'(OFS_STAT));
  assign hitMask = wrEn && (wrAddr == ADDR_W'(OFS_MASK));
  assign hitWd   = wrEn && (wrAddr == ADDR_W'(OFS_WDONE));

  assign unusedData = ^wrData;

  always_comb begin
    st.ldLo     = hitLo;
    st.ldHi     = hitHi;
    st.ldStep   = hitStep;
    st.cmpOn    = ctrlReg[0];
    st.stepMode = ctrlReg[1];
  end

  assign wdSet = {hitCtrl, hitStep, hitHi, hitLo};
  assign wdClr = hitWd ? {wrData[WD_BIT_CTRL], wrData[WD_BIT_STEP],
                          wrData[WD_BIT_HI], wrData[WD_BIT_LO]} : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      maskReg <= 1'b0;
      statReg <= 1'b0;
      wdReg   <= '0;
    end else begin
      if (hitCtrl) ctrlReg <= wrData[1:0];
      if (hitMask) maskReg <= wrData[0];
      if (match)
        statReg <= 1'b1;
      else if (hitStat && wrData[0])
        statReg <= 1'b0;
      wdReg <= (wdReg & ~wdClr) | wdSet;
    end
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADDR_W'(OFS_CMP_LO): rdData = cmpLoRd;
      ADDR_W'(OFS_CMP_HI): rdData = cmpHiRd;
      ADDR_W'(OFS_STEP):   rdData = stepRd;
      ADDR_W'(OFS_CTRL):   rdData[1:0] = ctrlReg;
      ADDR_W'(OFS_STAT):   rdData[0] = statReg;
      ADDR_W'(OFS_MASK):   rdData[0] = maskReg;
      ADDR_W'(OFS_WDONE): begin
        rdData[WD_BIT_LO]   = wdReg[0];
        rdData[WD_BIT_HI]   = wdReg[1];
        rdData[WD_BIT_STEP] = wdReg[2];
        rdData[WD_BIT_CTRL] = wdReg[3];
      end
      default: rdData = '0;
    endcase
  end

  assign irq = statReg & maskReg;

  // R3: a match always leaves the status set
  a_r3_match_latches: assert property (@(posedge clk) disable iff (!rstN)
    match |=> statReg);

  // R10: a target-low write raises its write-done flag
  a_r10_lo_done: assert property (@(posedge clk) disable iff (!rstN)
    hitLo |=> wdReg[0]);

  // R10: a control write raises its write-done flag
  a_r10_ctrl_done: assert property (@(posedge clk) disable iff (!rstN)
    hitCtrl |=> wdReg[3]);

  // R9: the line never rises without the mask
  a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> maskReg);

endmodule

// File: rtl/event_comparator.sv
module event_comparator
  import cmp_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  countIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);

  cmpStrobes_t       strobes;
  logic              matchHit;
  logic [DATA_W-1:0] cmpLoRd;
  logic [DATA_W-1:0] cmpHiRd;
  logic [DATA_W-1:0] stepRd;

  cmp_ctrl #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .rdAddr  (rdAddr),
    .match   (matchHit),
    .cmpLoRd (cmpLoRd),
    .cmpHiRd (cmpHiRd),
    .stepRd  (stepRd),
    .st      (strobes),
    .rdData  (rdData),
    .irq     (irq)
  );

  cmp_datapath #(
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .st      (strobes),
    .wrData  (wrData),
    .countIn (countIn),
    .match   (matchHit),
    .cmpLoRd (cmpLoRd),
    .cmpHiRd (cmpHiRd),
    .stepRd  (stepRd)
  );

endmodule

// File: tb/test_event_comparator.sv
module test_event_comparator;

  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] A_LO = 4'd0, A_HI = 4'd1, A_STEP = 4'd2, A_CTRL = 4'd3,
                         A_STAT = 4'd4, A_MASK = 4'd5, A_WD = 4'd6;

  typedef struct packed {
    logic [63:0] cmp;
    logic [31:0] step;
    logic [1:0]  ctrl;
    logic [63:0] count;
    logic        expStat;
    logic [63:0] expCmp;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{64'h0000_0001_0000_0010, 32'd5,          2'd1, 64'h0000_0001_0000_0010, 1'b1, 64'h0000_0001_0000_0010},
    '{64'h0000_0000_FFFF_FFFE, 32'd4,          2'd3, 64'h0000_0000_FFFF_FFFE, 1'b1, 64'h0000_0001_0000_0002},
    '{64'hFFFF_FFFF_FFFF_FFFF, 32'd2,          2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 64'h0000_0000_0000_0001},
    '{64'd100,                 32'd7,          2'd2, 64'd100,                 1'b0, 64'd100},
    '{64'd200,                 32'd7,          2'd1, 64'd201,                 1'b0, 64'd200},
    '{64'd300,                 32'd7,          2'd0, 64'd300,                 1'b0, 64'd300},
    '{64'h8000_0000_0000_0000, 32'hFFFF_FFFF,  2'd3, 64'h8000_0000_0000_0000, 1'b1, 64'h8000_0000_FFFF_FFFF}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] countIn = '0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [3:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  event_comparator i_event_comparator (
    .clk     (clk),
    .rstN    (rstN),
    .countIn (countIn),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .rdAddr  (rdAddr),
    .rdData  (rdData),
    .irq     (irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic rdCmp(output logic [63:0] v);
    logic [31:0] lo, hi;
    rd(A_LO, lo);
    rd(A_HI, hi);
    v = {hi, lo};
  endtask

  task automatic setup(input logic [63:0] cmp, input logic [31:0] step,
                       input logic [1:0] ctrl, input logic [63:0] parkCount);
    wr(A_CTRL, 32'd0);
    wr(A_STAT, 32'd1);
    @(negedge clk);
    countIn = parkCount;
    wr(A_LO, cmp[31:0]);
    wr(A_HI, cmp[63:32]);
    wr(A_STEP, step);
    wr(A_CTRL, {30'd0, ctrl});
  endtask

  initial begin
    repeat (CLK_PERIOD * 10000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [63:0] c;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), r);
      chk("R1 reset read", {32'd0, r}, 64'd0);
    end
    chk("R1 reset irq", {63'd0, irq}, 64'd0);

    // R10: write-done flags
    wr(A_LO, 32'h1234);
    rd(A_WD, r); chk("R10 lo flag", {32'd0, r}, 64'h1);
    wr(A_HI, 32'h5);
    rd(A_WD, r); chk("R10 hi flag", {32'd0, r}, 64'h3);
    wr(A_STEP, 32'h9);
    rd(A_WD, r); chk("R10 step flag", {32'd0, r}, 64'h7);
    wr(A_CTRL, 32'd0);
    rd(A_WD, r); chk("R10 ctrl flag", {32'd0, r}, 64'h10007);
    wr(A_WD, 32'h5);
    rd(A_WD, r); chk("R10 partial clear", {32'd0, r}, 64'h10002);
    wr(A_WD, 32'hFFFF_FFFF);
    rd(A_WD, r); chk("R10 full clear", {32'd0, r}, 64'h0);

    // R2: readback
    rdCmp(c); chk("R2 target readback", c, 64'h0000_0005_0000_1234);
    rd(A_STEP, r); chk("R2 step readback", {32'd0, r}, 64'h9);
    wr(A_CTRL, 32'h2);
    rd(A_CTRL, r); chk("R2 ctrl readback", {32'd0, r}, 64'h2);
    wr(A_MASK, 32'h1);
    rd(A_MASK, r); chk("R2 mask readback", {32'd0, r}, 64'h1);
    wr(A_MASK, 32'h0);

    // R12: unused address
    wr(4'hA, 32'hFFFF_FFFF);
    rd(4'hA, r); chk("R12 unused read", {32'd0, r}, 64'd0);
    rd(A_CTRL, r); chk("R12 ctrl untouched", {32'd0, r}, 64'h2);
    rdCmp(c); chk("R12 target untouched", c, 64'h0000_0005_0000_1234);
    rd(A_MASK, r); chk("R12 mask untouched", {32'd0, r}, 64'h0);

    // R3 R4 R6 R7: vector table
    for (int i = 0; i < NV; i++) begin
      setup(VECS[i].cmp, VECS[i].step, VECS[i].ctrl, ~VECS[i].count);
      @(negedge clk);
      countIn = VECS[i].count;
      @(negedge clk);
      rd(A_STAT, r);
      chk($sformatf("R3/R4 vec%0d status", i), {63'd0, r[0]}, {63'd0, VECS[i].expStat});
      rdCmp(c);
      chk($sformatf("R6/R7 vec%0d target", i), c, VECS[i].expCmp);
    end

    // R5: held count, step zero
    setup(64'd50, 32'd0, 2'd3, ~64'd50);
    @(negedge clk);
    countIn = 64'd50;
    @(negedge clk);
    rd(A_STAT, r); chk("R5 first match", {63'd0, r[0]}, 64'd1);
    // R8: writing zero keeps status
    wr(A_STAT, 32'd0);
    rd(A_STAT, r); chk("R8 write zero keeps", {63'd0, r[0]}, 64'd1);
    wr(A_STAT, 32'd1);
    rd(A_STAT, r); chk("R8 w1c clears", {63'd0, r[0]}, 64'd0);
    repeat (3) @(negedge clk);
    rd(A_STAT, r); chk("R5 no second match", {63'd0, r[0]}, 64'd0);
    rdCmp(c); chk("R5 target same", c, 64'd50);

    // R8: match and clear in the same cycle
    @(negedge clk);
    countIn = ~64'd50;
    @(negedge clk);
    countIn = 64'd50;
    wrEn = 1'b1; wrAddr = A_STAT; wrData = 32'd1;
    @(negedge clk);
    wrEn = 1'b0;
    rd(A_STAT, r); chk("R8 set beats clear", {63'd0, r[0]}, 64'd1);

    // R9: interrupt gating
    chk("R9 masked off", {63'd0, irq}, 64'd0);
    wr(A_MASK, 32'd1);
    #1;
    chk("R9 unmasked", {63'd0, irq}, 64'd1);
    wr(A_STAT, 32'd1);
    #1;
    chk("R9 after clear", {63'd0, irq}, 64'd0);

    // R11: software write beats step
    setup(64'h0000_0005_0000_0010, 32'h20, 2'd3, 64'd7);
    @(negedge clk);
    countIn = 64'h0000_0005_0000_0010;
    wrEn = 1'b1; wrAddr = A_LO; wrData = 32'h77;
    @(negedge clk);
    wrEn = 1'b0;
    rdCmp(c); chk("R11 write wins", c, 64'h0000_0005_0000_0077);
    rd(A_STAT, r); chk("R11 status still set", {63'd0, r[0]}, 64'd1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule